// File: doc/BRIEF.md
# Parity-Guarded Translation Entry Array

A small fully associative translation buffer in which each entry keeps a tag, a data word and a lock flag. The tag and the data each carry one parity bit. The lock flag is kept as an odd number of copies and is read by majority, so a single upset copy never changes the result and never raises an error. Every fill rewrites the tag, the data, both parity bits and all lock copies.

The array has three access paths. A combinational lookup port compares a key against all valid entries. A diagnostic port reads the tag or the data of one entry chosen by index. A fill port writes one entry by index. A parity failure on either read path removes the faulty entry at the next clock edge. A failure on the diagnostic path also sets a sticky urgent-error flag, which stays set until it is cleared by a one-cycle clear pulse.

A fault-injection port flips one stored tag bit, one data bit or one lock copy. It is used to exercise the majority vote and the parity detection.

Top module: `xlat_entry_array`

## Requirements
- R1: A fill writes the entry at `wr_idx`. A later lookup with an equal key gives `lk_hit`=1 with that entry's data and lock. When several valid entries match, the lowest index wins.
- R2: When `lk_en` is 0, or no valid entry matches, `lk_hit`, `lk_err`, `lk_data` and `lk_lock` are all 0.
- R3: The lock value is the majority of its copies. One flipped copy changes neither the lock value nor any error output.
- R4: A lookup whose matching entry fails tag parity gives `lk_hit`=0 and `lk_err`=1, and the entry is invalid from the next clock edge. Tag parity covers the tag bits only.
- R5: A lookup whose matching entry fails data parity gives `lk_hit`=0 and `lk_err`=1, and the entry is invalid from the next clock edge.
- R6: A diagnostic read returns the tag when `dg_sel`=0, zero-extended to DATA_W, and the data when `dg_sel`=1. It returns 0 when `dg_en`=0. `dg_perr` is 0 for an entry with intact parity or an invalid entry.
- R7: A diagnostic read of a valid entry whose selected field fails parity gives `dg_perr`=1 and the raw stored field, and the entry is invalid from the next clock edge.
- R8: `urgent_err` becomes 1 on the clock edge after `dg_perr`=1 and stays 1 until a cycle with `err_clr`=1. It is 0 after that edge. Clear wins over a new error in the same cycle. Lookup errors do not set it.
- R9: After reset every entry is invalid, all stored fields are zero and `urgent_err` is 0.
- R10: A fill writes fresh parity bits and all lock copies, so a fill over a corrupted entry leaves it clean.
- R11: Injection flips one stored bit of the entry at `inj_idx` on the clock edge. The `inj_fld` encoding is 0 for a tag bit, 1 for a data bit and 2 for a lock copy, and `inj_bit` gives the bit or copy number. A fill to the same entry in the same cycle takes priority over the flip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Fill strobe |
| wr_idx | input | IDX_W | Entry to fill |
| wr_tag | input | TAG_W | Tag to store |
| wr_data | input | DATA_W | Data to store |
| wr_lock | input | 1 | Lock value to store |
| lk_en | input | 1 | Lookup enable |
| lk_key | input | TAG_W | Lookup key |
| lk_hit | output | 1 | Clean match found |
| lk_err | output | 1 | Match found with bad parity |
| lk_data | output | DATA_W | Data of hit entry |
| lk_lock | output | 1 | Voted lock of hit entry |
| dg_en | input | 1 | Diagnostic read enable |
| dg_idx | input | IDX_W | Entry to read |
| dg_sel | input | 1 | 0 tag, 1 data |
| dg_rdata | output | DATA_W | Diagnostic read value |
| dg_perr | output | 1 | Parity failure on diagnostic read |
| err_clr | input | 1 | Clears urgent_err |
| urgent_err | output | 1 | Sticky diagnostic-error flag |
| inj_en | input | 1 | Fault injection strobe |
| inj_idx | input | IDX_W | Entry to corrupt |
| inj_fld | input | 2 | Field to corrupt |
| inj_bit | input | SEL_W | Bit or copy number |

## Verification
A lost or stuck valid bit shows at the lookup port in the same cycle the entry is probed: either a missing hit or a hit that should have been removed. A wrongly computed parity bit shows as `lk_err` or `dg_perr` on the first read after a fill. A broken majority vote shows on the first lookup after a lock copy is flipped. A stuck sticky flag shows one cycle after a diagnostic error or a clear.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   typedef enum logic [1:0] {
      INJ_TAG  = 2'd0,
      INJ_DATA = 2'd1,
      INJ_LOCK = 2'd2
   } inj_fld_e;
endpackage

// File: rtl/xlat_entry.sv
module xlat_entry
   import xlat_pkg::*;
#(
   parameter int TAG_W   = 20,
   parameter int DATA_W  = 24,
   parameter int COPIES  = 3,
   parameter int SEL_W   = 5,
   parameter bit ODD_PAR = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_lock,
   input  logic              kill,
   input  logic              inj,
   input  logic [1:0]        inj_fld,
   input  logic [SEL_W-1:0]  inj_bit,
   output logic              valid,
   output logic [TAG_W-1:0]  tag,
   output logic [DATA_W-1:0] data,
   output logic              lock,
   output logic              tag_ok,
   output logic              data_ok
);
   localparam logic PINV = ODD_PAR;

   logic              vld_q;
   logic [TAG_W-1:0]  tag_q;
   logic [DATA_W-1:0] data_q;
   logic              tpar_q, dpar_q;
   logic [COPIES-1:0] lock_q;
   logic              wr_tpar, wr_dpar;
   logic [TAG_W-1:0]  tmask;
   logic [DATA_W-1:0] dmask;
   logic [COPIES-1:0] lmask;
   inj_fld_e          fld;

   generate
      if (ODD_PAR) begin : g_odd
         assign wr_tpar = ~^wr_tag;
         assign wr_dpar = ~^wr_data;
      end else begin : g_even
         assign wr_tpar = ^wr_tag;
         assign wr_dpar = ^wr_data;
      end
      if (COPIES == 1) begin : g_single
         assign lock = lock_q[0];
      end else begin : g_vote
         assign lock = ($countones(lock_q) > (COPIES / 2));
      end
   endgenerate

   assign fld   = inj_fld_e'(inj_fld);
   assign tmask = TAG_W'(1) << inj_bit;
   assign dmask = DATA_W'(1) << inj_bit;
   assign lmask = COPIES'(1) << inj_bit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         tag_q  <= '0;
         data_q <= '0;
         tpar_q <= PINV;
         dpar_q <= PINV;
         lock_q <= '0;
      end else if (wr) begin
         vld_q  <= 1'b1;
         tag_q  <= wr_tag;
         data_q <= wr_data;
         tpar_q <= wr_tpar;
         dpar_q <= wr_dpar;
         lock_q <= {COPIES{wr_lock}};
      end else begin
         if (kill) vld_q <= 1'b0;
         if (inj) begin
            case (fld)
               INJ_TAG:  tag_q  <= tag_q ^ tmask;
               INJ_DATA: data_q <= data_q ^ dmask;
               INJ_LOCK: lock_q <= lock_q ^ lmask;
               default:  ;
            endcase
         end
      end
   end

   assign valid   = vld_q;
   assign tag     = tag_q;
   assign data    = data_q;
   assign tag_ok  = ((^tag_q) ^ tpar_q) == PINV;
   assign data_ok = ((^data_q) ^ dpar_q) == PINV;
endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
   parameter int N      = 16,
   parameter int TAG_W  = 20,
   parameter int DATA_W = 24,
   parameter int IDX_W  = 4
)(
   input  logic                      en,
   input  logic [TAG_W-1:0]          key,
   input  logic [N-1:0]              vld,
   input  logic [N-1:0][TAG_W-1:0]   tags,
   input  logic [N-1:0][DATA_W-1:0]  datas,
   input  logic [N-1:0]              locks,
   input  logic [N-1:0]              tok,
   input  logic [N-1:0]              dok,
   output logic                      hit,
   output logic                      err,
   output logic [IDX_W-1:0]          idx,
   output logic [DATA_W-1:0]         data,
   output logic                      lock
);
   logic found;
   logic sel_ok;

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = 0; i < N; i++) begin
         if (!found && vld[i] && (tags[i] == key)) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end

   assign sel_ok = tok[idx] & dok[idx];
   assign hit    = en & found & sel_ok;
   assign err    = en & found & ~sel_ok;
   assign data   = hit ? datas[idx] : '0;
   assign lock   = hit & locks[idx];
endmodule

// File: rtl/xlat_sticky.sv
module xlat_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n)   q <= 1'b0;
      else if (clr) q <= 1'b0;
      else if (set) q <= 1'b1;
   end
endmodule

// File: rtl/xlat_entry_array.sv
module xlat_entry_array #(
   parameter int ENTRIES = 16,
   parameter int TAG_W   = 20,
   parameter int DATA_W  = 24,
   parameter int COPIES  = 3,
   parameter bit ODD_PAR = 1'b0,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int SEL_W  = $clog2(DATA_W)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_lock,
   input  logic              lk_en,
   input  logic [TAG_W-1:0]  lk_key,
   output logic              lk_hit,
   output logic              lk_err,
   output logic [DATA_W-1:0] lk_data,
   output logic              lk_lock,
   input  logic              dg_en,
   input  logic [IDX_W-1:0]  dg_idx,
   input  logic              dg_sel,
   output logic [DATA_W-1:0] dg_rdata,
   output logic              dg_perr,
   input  logic              err_clr,
   output logic              urgent_err,
   input  logic              inj_en,
   input  logic [IDX_W-1:0]  inj_idx,
   input  logic [1:0]        inj_fld,
   input  logic [SEL_W-1:0]  inj_bit
);
   generate
      if (ENTRIES < 2)          begin : g_bad_n   $error("ENTRIES must be at least 2");     end
      if (DATA_W < TAG_W)       begin : g_bad_w   $error("DATA_W must not be below TAG_W"); end
      if ((COPIES % 2) == 0)    begin : g_bad_c   $error("COPIES must be odd");             end
      if (COPIES > DATA_W)      begin : g_bad_cw  $error("COPIES too large for inj_bit");   end
   endgenerate

   logic [ENTRIES-1:0]             vld_vec;
   logic [ENTRIES-1:0][TAG_W-1:0]  tag_vec;
   logic [ENTRIES-1:0][DATA_W-1:0] data_vec;
   logic [ENTRIES-1:0]             lock_vec;
   logic [ENTRIES-1:0]             tok_vec;
   logic [ENTRIES-1:0]             dok_vec;
   logic [IDX_W-1:0]               lk_idx;
   logic                           dg_bad;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic kill_e;
      assign kill_e = (lk_err && (lk_idx == IDX_W'(e))) ||
                      (dg_perr && (dg_idx == IDX_W'(e)));
      xlat_entry #(
         .TAG_W(TAG_W), .DATA_W(DATA_W), .COPIES(COPIES),
         .SEL_W(SEL_W), .ODD_PAR(ODD_PAR)
      ) u_ent (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr      (wr_en && (wr_idx == IDX_W'(e))),
         .wr_tag  (wr_tag),
         .wr_data (wr_data),
         .wr_lock (wr_lock),
         .kill    (kill_e),
         .inj     (inj_en && (inj_idx == IDX_W'(e))),
         .inj_fld (inj_fld),
         .inj_bit (inj_bit),
         .valid   (vld_vec[e]),
         .tag     (tag_vec[e]),
         .data    (data_vec[e]),
         .lock    (lock_vec[e]),
         .tag_ok  (tok_vec[e]),
         .data_ok (dok_vec[e])
      );
   end

   xlat_match #(
      .N(ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
   ) u_match (
      .en    (lk_en),
      .key   (lk_key),
      .vld   (vld_vec),
      .tags  (tag_vec),
      .datas (data_vec),
      .locks (lock_vec),
      .tok   (tok_vec),
      .dok   (dok_vec),
      .hit   (lk_hit),
      .err   (lk_err),
      .idx   (lk_idx),
      .data  (lk_data),
      .lock  (lk_lock)
   );

   assign dg_bad   = dg_sel ? ~dok_vec[dg_idx] : ~tok_vec[dg_idx];
   assign dg_perr  = dg_en & vld_vec[dg_idx] & dg_bad;
   assign dg_rdata = !dg_en ? '0 :
                     dg_sel ? data_vec[dg_idx] : DATA_W'(tag_vec[dg_idx]);

   xlat_sticky u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (dg_perr),
      .clr   (err_clr),
      .q     (urgent_err)
   );
endmodule

// File: rtl/xlat_chk.sv
module xlat_chk #(
   parameter int N     = 16,
   parameter int IDX_W = 4
)(
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             lk_en,
   input logic             lk_hit,
   input logic             lk_err,
   input logic [IDX_W-1:0] lk_idx,
   input logic             dg_perr,
   input logic [IDX_W-1:0] dg_idx,
   input logic             err_clr,
   input logic             urgent_err,
   input logic [N-1:0]     vld_vec
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_en |-> (!lk_hit && !lk_err)); // R2
   AST_HIT_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(lk_hit && lk_err)); // R4
   AST_LOOKUP_DEMAP: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_err && !wr_en) |=> !vld_vec[$past(lk_idx)]); // R5
   AST_DIAG_DEMAP: assert property (@(posedge clk) disable iff (!rst_n)
      (dg_perr && !wr_en) |=> !vld_vec[$past(dg_idx)]); // R7
   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (dg_perr && !err_clr) |=> urgent_err); // R8
   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (urgent_err && !err_clr) |=> urgent_err); // R8
   AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      err_clr |=> !urgent_err); // R8
   AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(urgent_err) |-> $past(dg_perr)); // R8
endmodule

bind xlat_entry_array xlat_chk #(.N(ENTRIES), .IDX_W(IDX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .lk_en      (lk_en),
   .lk_hit     (lk_hit),
   .lk_err     (lk_err),
   .lk_idx     (lk_idx),
   .dg_perr    (dg_perr),
   .dg_idx     (dg_idx),
   .err_clr    (err_clr),
   .urgent_err (urgent_err),
   .vld_vec    (vld_vec)
);

// File: tb/sim_xlat_entry_array.sv
module sim_xlat_entry_array;
   localparam int TW = 20;
   localparam int DW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 0, wr_lock = 0, lk_en = 0, dg_en = 0, dg_sel = 0;
   logic          err_clr = 0, inj_en = 0;
   logic [3:0]    wr_idx = 0, dg_idx = 0, inj_idx = 0;
   logic [TW-1:0] wr_tag = 0, lk_key = 0;
   logic [DW-1:0] wr_data = 0;
   logic [1:0]    inj_fld = 0;
   logic [4:0]    inj_bit = 0;
   logic          lk_hit, lk_err, lk_lock, dg_perr, urgent_err;
   logic [DW-1:0] lk_data, dg_rdata;

   always #2.5 clk = ~clk;

   xlat_entry_array u0 (.*);

   typedef struct {
      bit            c_lk, c_dg, c_fl;
      logic          hit, err, lock, perr, fl;
      logic [DW-1:0] data, rd;
      string         req;
   } item_t;

   item_t q[$];
   int    n_run = 0, n_fail = 0;

   function automatic item_t blank(string r);
      item_t it;
      it.c_lk = 0; it.c_dg = 0; it.c_fl = 0;
      it.hit = 0; it.err = 0; it.lock = 0; it.perr = 0; it.fl = 0;
      it.data = '0; it.rd = '0; it.req = r;
      return it;
   endfunction

   task automatic quiet();
      wr_en = 0; lk_en = 0; dg_en = 0; err_clr = 0; inj_en = 0;
   endtask

   task automatic fill(input logic [3:0] i, input logic [TW-1:0] t,
                       input logic [DW-1:0] d, input logic l);
      @(negedge clk); quiet();
      wr_en = 1; wr_idx = i; wr_tag = t; wr_data = d; wr_lock = l;
      q.push_back(blank("fill"));
   endtask

   task automatic fill_inj(input logic [3:0] i, input logic [TW-1:0] t,
                           input logic [DW-1:0] d, input logic [1:0] f,
                           input logic [4:0] b);
      @(negedge clk); quiet();
      wr_en = 1; wr_idx = i; wr_tag = t; wr_data = d; wr_lock = 0;
      inj_en = 1; inj_idx = i; inj_fld = f; inj_bit = b;
      q.push_back(blank("fill_inj"));
   endtask

   task automatic inject(input logic [3:0] i, input logic [1:0] f,
                         input logic [4:0] b);
      @(negedge clk); quiet();
      inj_en = 1; inj_idx = i; inj_fld = f; inj_bit = b;
      q.push_back(blank("inject"));
   endtask

   task automatic look(input logic [TW-1:0] k, input logic en, input logic h,
                       input logic e, input logic [DW-1:0] d, input logic l,
                       input string r);
      item_t it;
      @(negedge clk); quiet();
      lk_en = en; lk_key = k;
      it = blank(r); it.c_lk = 1;
      it.hit = h; it.err = e; it.data = d; it.lock = l;
      q.push_back(it);
   endtask

   task automatic diag(input logic [3:0] i, input logic s, input logic c,
                       input logic [DW-1:0] rd, input logic pe, input string r);
      item_t it;
      @(negedge clk); quiet();
      dg_en = 1; dg_idx = i; dg_sel = s; err_clr = c;
      it = blank(r); it.c_dg = 1; it.rd = rd; it.perr = pe;
      q.push_back(it);
   endtask

   task automatic flag(input logic c, input logic ex, input string r);
      item_t it;
      @(negedge clk); quiet();
      err_clr = c;
      it = blank(r); it.c_fl = 1; it.fl = ex;
      q.push_back(it);
   endtask

   task automatic cmp(input string r, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
      end
   endtask

   // monitor: sample mid-cycle, after the driver set up the inputs
   initial begin
      forever begin
         @(negedge clk); #2;
         if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            if (it.c_lk) begin
               cmp(it.req, "lk_hit",  DW'(lk_hit),  DW'(it.hit));
               cmp(it.req, "lk_err",  DW'(lk_err),  DW'(it.err));
               cmp(it.req, "lk_data", lk_data,      it.data);
               cmp(it.req, "lk_lock", DW'(lk_lock), DW'(it.lock));
            end
            if (it.c_dg) begin
               cmp(it.req, "dg_rdata", dg_rdata,     it.rd);
               cmp(it.req, "dg_perr",  DW'(dg_perr), DW'(it.perr));
            end
            if (it.c_fl)
               cmp(it.req, "urgent_err", DW'(urgent_err), DW'(it.fl));
         end
      end
   end

   bit done = 0;
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      // R9: reset state
      flag(0, 0, "R9");
      look(20'h00000, 1, 0, 0, 0, 0, "R9");
      diag(4'd0, 1, 0, 24'h0, 0, "R9");
      // R1: fills and lookups, lowest index priority
      fill(4'd0, 20'hA1234, 24'h5A5A01, 1);
      fill(4'd1, 20'h0BEEF, 24'h00C0DE, 0);
      fill(4'd9, 20'h33333, 24'h222222, 0);
      fill(4'd5, 20'h33333, 24'h111111, 1);
      look(20'hA1234, 1, 1, 0, 24'h5A5A01, 1, "R1");
      look(20'h0BEEF, 1, 1, 0, 24'h00C0DE, 0, "R1");
      look(20'h33333, 1, 1, 0, 24'h111111, 1, "R1 priority");
      // R2: disabled and absent
      look(20'hA1234, 0, 0, 0, 0, 0, "R2 disabled");
      look(20'h77777, 1, 0, 0, 0, 0, "R2 absent");
      // R3 / R11: lock copy flips (inj_fld 2)
      inject(4'd0, 2'd2, 5'd1);
      look(20'hA1234, 1, 1, 0, 24'h5A5A01, 1, "R3 copy1");
      inject(4'd1, 2'd2, 5'd2);
      look(20'h0BEEF, 1, 1, 0, 24'h00C0DE, 0, "R3 copy2");
      // R6: clean diagnostic reads
      diag(4'd0, 0, 0, 24'h0A1234, 0, "R6 tag");
      diag(4'd0, 1, 0, 24'h5A5A01, 0, "R6 data");
      // R5 / R11: data fault (inj_fld 1) on entry 1
      inject(4'd1, 2'd1, 5'd3);
      look(20'h0BEEF, 1, 0, 1, 0, 0, "R5 error");
      look(20'h0BEEF, 1, 0, 0, 0, 0, "R5 demapped");
      flag(0, 0, "R8 lookup no flag");
      // R4 / R11: tag fault (inj_fld 0) on entry 0
      inject(4'd0, 2'd0, 5'd0);
      look(20'hA1234, 1, 0, 0, 0, 0, "R4 old key");
      look(20'hA1235, 1, 0, 1, 0, 0, "R4 error");
      look(20'hA1235, 1, 0, 0, 0, 0, "R4 demapped");
      // R7 / R8: diagnostic data error
      fill(4'd2, 20'h44444, 24'h0F0F0F, 0);
      inject(4'd2, 2'd1, 5'd23);
      diag(4'd2, 1, 0, 24'h8F0F0F, 1, "R7 data perr");
      flag(0, 1, "R8 set");
      look(20'h44444, 1, 0, 0, 0, 0, "R7 demapped");
      flag(0, 1, "R8 hold");
      flag(1, 1, "R8 clear cycle");
      flag(0, 0, "R8 cleared");
      // R7 / R8: tag error with clear in same cycle
      fill(4'd3, 20'h55555, 24'h000055, 0);
      inject(4'd3, 2'd0, 5'd19);
      diag(4'd3, 0, 1, 24'h0D5555, 1, "R7 tag perr");
      flag(0, 0, "R8 clear wins");
      // R10: refill of corrupted entry
      fill(4'd6, 20'h66666, 24'h000066, 1);
      inject(4'd6, 2'd1, 5'd5);
      fill(4'd6, 20'h66666, 24'h000066, 1);
      look(20'h66666, 1, 1, 0, 24'h000066, 1, "R10");
      diag(4'd6, 1, 0, 24'h000066, 0, "R10");
      // R11: fill beats injection in the same cycle
      fill_inj(4'd7, 20'h07777, 24'h777777, 2'd0, 5'd2);
      look(20'h07777, 1, 1, 0, 24'h777777, 0, "R11");
      @(negedge clk); quiet();
      while (q.size() > 0) @(negedge clk);
      repeat (2) @(negedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule